// File: doc/BRIEF.md
# Audio Soft and Hard Mute Controller

This block sits in the sample path ahead of a rate converter's input FIFO. It scales each signed PCM sample by a gain that a ramp counter sets. The ramp counter moves one step per frame-sync strobe. A soft-mute request fades the stream out over 4096 strobes, and releasing it fades the stream back in. A hard-mute control and an auto-mute control both silence the path at once. Auto mute acts on a "non-audio" flag from an upstream digital-audio receiver.

A combinational mute-status output reports whether any mute source is active or the ramp is away from unity. A sticky interrupt request can be armed for the rising edge of that status, the falling edge, or both. The interrupt also fires once when 4096 strobes have passed since reset or since the last rate-change pulse. Software clears the request through a write-one-to-clear input.

Top module: `audio_mute_ctl`

## Requirements
- R1: On each cycle with `fs_stb` high, `sample_out` is loaded with `(sample_in * (4096 - c)) >>> 12`, where c is the ramp count before that strobe and starts at 0 after reset. With c = 0 the sample passes through unchanged.
- R2: While `soft_mute` is high, each strobe raises c by one until it saturates at 4096. From the strobe taken at c = 4096 onward, `sample_out` is exactly 0.
- R3: While `soft_mute` is low, each strobe lowers c by one down to 0. A release partway through the ramp reverses from the current count without restarting, and a release from full mute takes 4096 strobes to reach unity gain.
- R4: A strobe taken while `hard_mute_en` is 1 loads 0 into `sample_out`, whatever the ramp count.
- R5: A strobe taken while `auto_mute_en` and `rx_nonaudio` are both 1 loads 0. When `auto_mute_en` is 0, `rx_nonaudio` has no effect on the sample or on the status.
- R6: `mute_out` is 1 exactly when `hard_mute_en` is 1, or `auto_mute_en` and `rx_nonaudio` are both 1, or c is non-zero.
- R7: A 0-to-1 change of `mute_out` sets `irq` on the next clock edge when `irq_rise_en` is 1. A 1-to-0 change sets it when `irq_fall_en` is 1. An edge whose enable is 0 leaves `irq` unchanged.
- R8: `irq` is set once, on the 4096th strobe after reset or after a `rate_chg` pulse, and not again until the next `rate_chg`.
- R9: `irq` stays at 1 until a cycle with `irq_clr` high clears it. A new set event in the same cycle as `irq_clr` wins over the clear.
- R10: `sample_out` holds its value in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_stb | input | 1 | Input frame-sync strobe, one cycle per sample |
| sample_in | input | SAMPLE_W | Signed input sample |
| soft_mute | input | 1 | Ramped mute request |
| hard_mute_en | input | 1 | Immediate mute control |
| auto_mute_en | input | 1 | Lets `rx_nonaudio` mute the path |
| rx_nonaudio | input | 1 | Non-audio flag from the receiver |
| rate_chg | input | 1 | Pulse marking a sample-rate change; restarts lock timing |
| irq_rise_en | input | 1 | Interrupt on entering mute |
| irq_fall_en | input | 1 | Interrupt on leaving mute |
| irq_clr | input | 1 | Write-one-to-clear for `irq` |
| sample_out | output | SAMPLE_W | Attenuated sample, registered |
| mute_out | output | 1 | Mute status |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench targets the ends of the ramp. It checks that the strobe taken at count 4096 gives exact zero rather than a one-LSB residue, and that a full release lands back on bit-exact pass-through. A design that counted 4095 steps, or that rounded the product, would miss these values.

A partial fade that is released must be checked sample by sample. A design that restarted the counter would show a gain jump in the scoreboard.

The lock interrupt is probed one strobe before and on the 4096th strobe, then again after a rate change. This catches off-by-one lock timing and a lock event that fires more than once. Edge masks are tested one at a time, so that a swapped rise and fall enable raises `irq` on the wrong transition. Auto mute is tested with its enable low, so that a design reacting to the raw receiver flag is caught.

// File: rtl/audio_mute_pkg.sv
package audio_mute_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/mute_ramp.sv
module mute_ramp
  import audio_mute_pkg::*;
#(
  parameter int RAMP_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fs_stb,
  input  logic            soft_mute,
  output logic [RAMP_W:0] cnt_o,
  output logic            full_o
);
  localparam logic [RAMP_W:0] FULL = {1'b1, {RAMP_W{1'b0}}};
  localparam logic [RAMP_W:0] ONE  = {{RAMP_W{1'b0}}, 1'b1};

  logic [RAMP_W:0] cnt_q, cnt_d;
  ramp_dir_e       dir;

  always_comb begin
    if (soft_mute) dir = (cnt_q != FULL) ? RAMP_UP : RAMP_HOLD;
    else           dir = (cnt_q != '0)   ? RAMP_DOWN : RAMP_HOLD;
    case (dir)
      RAMP_UP:   cnt_d = cnt_q + ONE;
      RAMP_DOWN: cnt_d = cnt_q - ONE;
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (fs_stb) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == FULL);
endmodule

// File: rtl/mute_gain.sv
module mute_gain #(
  parameter int SAMPLE_W = 24,
  parameter int RAMP_W   = 12
) (
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic        [RAMP_W:0]     cnt,
  input  logic                       force_zero,
  output logic signed [SAMPLE_W-1:0] gained
);
  localparam int PW = SAMPLE_W + RAMP_W + 2;
  localparam logic [RAMP_W:0] FULL = {1'b1, {RAMP_W{1'b0}}};

  logic signed [RAMP_W+1:0] gain;
  logic signed [PW-1:0]     prod;
  logic                     gain_unused;

  always_comb begin
    gain   = {1'b0, FULL - cnt};
    prod   = PW'(sample_in) * PW'(gain);
    gained = force_zero ? '0 : prod[RAMP_W +: SAMPLE_W];
  end

  assign gain_unused = ^{prod[RAMP_W-1:0], prod[PW-1:RAMP_W+SAMPLE_W]};
endmodule

// File: rtl/mute_lock.sv
module mute_lock #(
  parameter int LOCK_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_stb,
  input  logic rate_chg,
  output logic lock_pulse
);
  localparam logic [LOCK_W-1:0] ONE = {{(LOCK_W-1){1'b0}}, 1'b1};

  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic              locked_q, locked_d;

  assign lock_pulse = fs_stb & ~locked_q & ~rate_chg & (cnt_q == '1);

  always_comb begin
    cnt_d    = cnt_q;
    locked_d = locked_q;
    if (rate_chg) begin
      cnt_d    = '0;
      locked_d = 1'b0;
    end else if (fs_stb && !locked_q) begin
      if (cnt_q == '1) locked_d = 1'b1;
      else             cnt_d    = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      locked_q <= locked_d;
    end
  end
endmodule

// File: rtl/mute_irq.sv
module mute_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_now,
  input  logic rise_en,
  input  logic fall_en,
  input  logic lock_pulse,
  input  logic clr,
  output logic irq
);
  logic prev_q, irq_q, irq_d;
  logic rise, fall;

  always_comb begin
    rise  = mute_now & ~prev_q;
    fall  = ~mute_now & prev_q;
    irq_d = (irq_q & ~clr) | (rise & rise_en) | (fall & fall_en) | lock_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= mute_now;
      irq_q  <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/audio_mute_ctl.sv
module audio_mute_ctl #(
  parameter int SAMPLE_W = 24,
  parameter int RAMP_W   = 12,
  parameter int LOCK_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fs_stb,
  input  logic signed [SAMPLE_W-1:0] sample_in,
  input  logic                       soft_mute,
  input  logic                       hard_mute_en,
  input  logic                       auto_mute_en,
  input  logic                       rx_nonaudio,
  input  logic                       rate_chg,
  input  logic                       irq_rise_en,
  input  logic                       irq_fall_en,
  input  logic                       irq_clr,
  output logic signed [SAMPLE_W-1:0] sample_out,
  output logic                       mute_out,
  output logic                       irq
);
  logic [RAMP_W:0]             ramp_cnt;
  logic                        ramp_full;
  logic                        instant_mute;
  logic                        lock_pulse;
  logic signed [SAMPLE_W-1:0]  gained;
  logic signed [SAMPLE_W-1:0]  out_q;

  assign instant_mute = hard_mute_en | (auto_mute_en & rx_nonaudio);
  assign mute_out     = instant_mute | (ramp_cnt != '0);

  mute_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_stb    (fs_stb),
    .soft_mute (soft_mute),
    .cnt_o     (ramp_cnt),
    .full_o    (ramp_full)
  );

  mute_gain #(.SAMPLE_W(SAMPLE_W), .RAMP_W(RAMP_W)) u_gain (
    .sample_in  (sample_in),
    .cnt        (ramp_cnt),
    .force_zero (instant_mute | ramp_full),
    .gained     (gained)
  );

  mute_lock #(.LOCK_W(LOCK_W)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs_stb     (fs_stb),
    .rate_chg   (rate_chg),
    .lock_pulse (lock_pulse)
  );

  mute_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mute_now   (mute_out),
    .rise_en    (irq_rise_en),
    .fall_en    (irq_fall_en),
    .lock_pulse (lock_pulse),
    .clr        (irq_clr),
    .irq        (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (fs_stb) out_q <= gained;
  end

  assign sample_out = out_q;
endmodule

// File: rtl/audio_mute_ctl_checker.sv
module audio_mute_ctl_checker #(
  parameter int SAMPLE_W = 24,
  parameter int RAMP_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fs_stb,
  input logic                hard_mute_en,
  input logic                auto_mute_en,
  input logic                rx_nonaudio,
  input logic                irq_clr,
  input logic [SAMPLE_W-1:0] sample_out,
  input logic                mute_out,
  input logic                irq,
  input logic [RAMP_W:0]     ramp_cnt
);
  localparam logic [RAMP_W:0] FULL = {1'b1, {RAMP_W{1'b0}}};

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_stb |=> $stable(sample_out));

  p_hard_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && hard_mute_en) |=> (sample_out == '0));

  p_auto_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && auto_mute_en && rx_nonaudio) |=> (sample_out == '0));

  p_full_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && ramp_cnt == FULL) |=> (sample_out == '0));

  p_ramp_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_cnt <= FULL);

  p_ramp_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_stb |=> $stable(ramp_cnt));

  p_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hard_mute_en || ramp_cnt != '0) |-> mute_out);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind audio_mute_ctl audio_mute_ctl_checker #(
  .SAMPLE_W(SAMPLE_W),
  .RAMP_W  (RAMP_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .fs_stb       (fs_stb),
  .hard_mute_en (hard_mute_en),
  .auto_mute_en (auto_mute_en),
  .rx_nonaudio  (rx_nonaudio),
  .irq_clr      (irq_clr),
  .sample_out   (sample_out),
  .mute_out     (mute_out),
  .irq          (irq),
  .ramp_cnt     (ramp_cnt)
);

// File: tb/audio_mute_ctl_bench.sv
`timescale 1ns/1ps
module audio_mute_ctl_bench;
  localparam int SW = 24;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 fs_stb;
  logic signed [SW-1:0] sample_in;
  logic                 soft_mute, hard_mute_en, auto_mute_en, rx_nonaudio;
  logic                 rate_chg, irq_rise_en, irq_fall_en, irq_clr;
  logic signed [SW-1:0] sample_out;
  logic                 mute_out, irq;

  int chk_cnt  = 0;
  int fail_cnt = 0;
  int mcnt     = 0;
  bit seen     = 1'b0;
  bit done     = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  audio_mute_ctl u_audio_mute_ctl (
    .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .sample_in(sample_in),
    .soft_mute(soft_mute), .hard_mute_en(hard_mute_en),
    .auto_mute_en(auto_mute_en), .rx_nonaudio(rx_nonaudio),
    .rate_chg(rate_chg), .irq_rise_en(irq_rise_en), .irq_fall_en(irq_fall_en),
    .irq_clr(irq_clr), .sample_out(sample_out), .mute_out(mute_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pat(input int i);
    return ((i * 40503 + 12345) % 16777216) - 8388608;
  endfunction

  // Driver: applies one strobe, pushes the expected output sample.
  task automatic frame(input int s);
    longint p;
    int     e;
    bit     inst;
    inst      = hard_mute_en | (auto_mute_en & rx_nonaudio);
    sample_in = s[SW-1:0];
    fs_stb    = 1'b1;
    p = longint'(s) * longint'(4096 - mcnt);
    e = (inst || mcnt == 4096) ? 0 : int'(p >>> 12);
    exp_q.push_back(e);
    if (soft_mute && mcnt < 4096)      mcnt++;
    else if (!soft_mute && mcnt > 0)   mcnt--;
    @(negedge clk);
    fs_stb = 1'b0;
    chk(mute_out == (inst | (mcnt != 0)), "R6 mute_out", int'(mute_out),
        int'(inst | (mcnt != 0)));
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  // Monitor: compares each registered output with the scoreboard head.
  always @(posedge clk) seen <= fs_stb;
  always @(negedge clk) begin
    if (seen) begin
      int e;
      e = exp_q.pop_front();
      chk(int'(sample_out) == e, "R1/R2/R3/R4/R5 sample", int'(sample_out), e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin
    int hold;
    rst_n = 1'b0; fs_stb = 1'b0; sample_in = '0; soft_mute = 1'b0;
    hard_mute_en = 1'b0; auto_mute_en = 1'b0; rx_nonaudio = 1'b0;
    rate_chg = 1'b0; irq_rise_en = 1'b0; irq_fall_en = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk(sample_out == '0, "R1 reset sample", int'(sample_out), 0);
    chk(mute_out == 1'b0, "R6 reset mute", int'(mute_out), 0);
    chk(irq == 1'b0, "R9 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 lock timing and R1 pass-through
    for (int i = 1; i <= 4096; i++) begin
      frame(pat(i));
      if (i == 4095) chk(irq == 1'b0, "R8 before lock", int'(irq), 0);
      if (i == 4096) chk(irq == 1'b1, "R8 at lock", int'(irq), 1);
    end
    pulse_clr();
    chk(irq == 1'b0, "R9 clear", int'(irq), 0);
    for (int i = 0; i < 50; i++) frame(pat(i + 7));
    chk(irq == 1'b0, "R8 lock fires once", int'(irq), 0);

    // R10 hold without strobe
    hold = int'(sample_out);
    repeat (6) @(negedge clk);
    chk(int'(sample_out) == hold, "R10 hold", int'(sample_out), hold);

    // R2 fade out with rise interrupt (R7)
    irq_rise_en = 1'b1;
    soft_mute = 1'b1;
    frame(pat(100));
    @(negedge clk);
    chk(irq == 1'b1, "R7 rise irq", int'(irq), 1);
    pulse_clr();
    for (int i = 1; i < 4096; i++) frame(pat(200 + i));
    frame(1234567);
    @(negedge clk);
    chk(sample_out == '0, "R2 full mute zero", int'(sample_out), 0);
    chk(irq == 1'b0, "R9 stays clear", int'(irq), 0);

    // R3 fade in with fall interrupt (R7)
    irq_rise_en = 1'b0;
    irq_fall_en = 1'b1;
    soft_mute = 1'b0;
    for (int i = 1; i <= 4096; i++) frame(pat(900 + i));
    @(negedge clk);
    chk(irq == 1'b1, "R7 fall irq", int'(irq), 1);
    pulse_clr();
    irq_fall_en = 1'b0;
    frame(-3000001);
    @(negedge clk);
    chk(int'(sample_out) == -3000001, "R3 unity after release", int'(sample_out), -3000001);

    // R3 partial reversal
    soft_mute = 1'b1;
    for (int i = 0; i < 300; i++) frame(pat(3000 + i));
    soft_mute = 1'b0;
    for (int i = 0; i < 300; i++) frame(pat(4000 + i));
    frame(7777777);
    @(negedge clk);
    chk(int'(sample_out) == 7777777, "R3 reversal returns to unity", int'(sample_out), 7777777);

    // R4 hard mute
    hard_mute_en = 1'b1;
    frame(5555555);
    @(negedge clk);
    chk(sample_out == '0, "R4 hard zero", int'(sample_out), 0);
    hard_mute_en = 1'b0;

    // R5 auto mute, gated by its enable
    rx_nonaudio = 1'b1;
    frame(4444444);
    @(negedge clk);
    chk(int'(sample_out) == 4444444, "R5 nonaudio ignored", int'(sample_out), 4444444);
    chk(mute_out == 1'b0, "R5 status ignored", int'(mute_out), 0);
    auto_mute_en = 1'b1;
    frame(4444444);
    @(negedge clk);
    chk(sample_out == '0, "R5 auto zero", int'(sample_out), 0);
    auto_mute_en = 1'b0;
    rx_nonaudio = 1'b0;
    repeat (2) @(negedge clk);
    pulse_clr();

    // R7 masks: fall only
    irq_fall_en = 1'b1;
    hard_mute_en = 1'b1;
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R7 rise masked", int'(irq), 0);
    hard_mute_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R7 fall enabled", int'(irq), 1);
    irq_fall_en = 1'b0;
    pulse_clr();

    // R8 relock after rate change
    rate_chg = 1'b1;
    @(negedge clk);
    rate_chg = 1'b0;
    for (int i = 1; i <= 4096; i++) begin
      frame(pat(8000 + i));
      if (i == 4095) chk(irq == 1'b0, "R8 before relock", int'(irq), 0);
      if (i == 4096) chk(irq == 1'b1, "R8 relock", int'(irq), 1);
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule